// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block is the host-side engine for Enhanced Parallel Port (version 1.7) transfers. A host writes or reads one of two dedicated registers, one for peripheral addresses and one for data. Each access starts one handshake on the parallel bus. That handshake uses a write-direction line, a separate strobe for address cycles and a separate strobe for data cycles, and the peripheral's wait line. The cycle stays in wait states for as long as the peripheral holds the wait line low. It finishes once the line goes high.

A watchdog guards every cycle. It counts clock-enable ticks from the start of the cycle. If the count reaches a parameterised limit before the peripheral responds, the cycle is abandoned and a sticky timeout flag is raised.

While no cycle is in progress, the port lines follow a standard-mode control register, and the bus driver enable follows that register's direction bit. The host sees a busy signal for the length of each cycle. The byte from a read cycle is returned on the host read-data output.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: With no cycle in progress, the port lines follow the control register: pp_nwrite = NOT ctrl[0], pp_ndstb = NOT ctrl[1], pp_ninit = ctrl[2], pp_nastb = NOT ctrl[3], pd_oe = NOT ctrl[5], and pd_out equals the data latch. After reset, the control register and the data latch are both 0.
- R2: A host access to address 3 runs an address cycle that pulses only pp_nastb. A host access to address 4 runs a data cycle that pulses only pp_ndstb. In both cases a write access gives a write cycle and a read access gives a read cycle.
- R3: In a write cycle, pp_nwrite is low, pd_oe is high and pd_out carries the written byte for one clock before the strobe falls. These levels are held for the whole time the strobe is low, and for one more clock after the strobe rises.
- R4: In a read cycle, pp_nwrite is high and pd_oe is low for one clock before the strobe falls, and until one clock after the strobe rises. On the clock edge where the cycle completes, the byte on pd_in is captured. It appears on host_rdata as host_busy falls.
- R5: While the synchronised pp_nwait is low, the strobe stays low. Once pp_nwait is high after its two-flop synchroniser, the cycle completes and the strobe rises.
- R6: The watchdog counts tick cycles from the start of each cycle. When TMO_TICKS ticks have been counted without completion, the cycle is aborted on the next clock, the strobe rises and the timeout flag is set. If completion and expiry occur in the same clock, completion takes priority. An aborted read returns 8'hFF.
- R7: Reading address 1 returns the timeout flag in bit 0, with all other bits 0. The flag stays set until a host write to address 1 with bit 0 = 1. A write to address 1 with bit 0 = 0 leaves it unchanged.
- R8: host_busy rises on the clock after an accepted cycle access and falls on the clock where the strobe is released. Every host access made while host_busy is high is ignored.
- R9: A write to address 0 loads the data latch, and a read of address 0 returns pd_in. Address 2 holds the 8-bit control register, which can be both written and read. A register read is returned on host_rdata one clock after the access.
- R10: The watchdog advances only in clocks where tick is high. With tick held low, a cycle never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for the watchdog |
| host_wr | input | 1 | Host write strobe, one clock wide |
| host_rd | input | 1 | Host read strobe, one clock wide |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_busy | output | 1 | High while a parallel cycle runs |
| pd_in | input | 8 | Parallel data bus input |
| pd_out | output | 8 | Parallel data bus output |
| pd_oe | output | 1 | Parallel data bus drive enable |
| pp_nwrite | output | 1 | Write-direction line, low for writes |
| pp_ndstb | output | 1 | Data strobe, active low |
| pp_nastb | output | 1 | Address strobe, active low |
| pp_ninit | output | 1 | Init line, from the control register |
| pp_nwait | input | 1 | Peripheral wait, low holds the cycle |

## Verification
The assertions assume that the host issues no cycle unless control bits 0, 1 and 3 are zero, so that the address and data strobes are never pulled low by the idle fallback while a cycle runs. They also assume pp_nwait is only ever used as a level that the synchroniser samples. The stimulus programs the control register to 8'h04 or 8'h24 before every cycle. A peripheral model drops pp_nwait whenever no strobe is low and raises it a fixed number of clocks after a strobe falls. Cycles are started only after host_busy has fallen, except in the one test that deliberately makes accesses while busy.

// File: rtl/epp_pkg.sv
package epp_pkg;
    localparam int EPP_DW = 8;

    localparam logic [2:0] ADR_DATA   = 3'd0;
    localparam logic [2:0] ADR_STATUS = 3'd1;
    localparam logic [2:0] ADR_CTRL   = 3'd2;
    localparam logic [2:0] ADR_EPPADR = 3'd3;
    localparam logic [2:0] ADR_EPPDAT = 3'd4;

    localparam int CB_WRLINE = 0;
    localparam int CB_DSLINE = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_ASLINE = 3;
    localparam int CB_DIR    = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_END    = 2'd3
    } cyc_state_e;

    typedef struct packed {
        cyc_state_e        st;
        logic              rd;
        logic              adr;
        logic [EPP_DW-1:0] val;
    } eng_reg_t;

    typedef struct packed {
        logic [EPP_DW-1:0] ctrl;
        logic [EPP_DW-1:0] dlat;
        logic              tmo;
        logic [EPP_DW-1:0] rdata;
    } host_reg_t;
endpackage

// File: rtl/epp_sync2.sv
module epp_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_lim;

    assign at_lim = (cnt_q == LIM);

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick && !at_lim) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && at_lim;
endmodule

// File: rtl/epp_engine.sv
module epp_engine
    import epp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic              start_adr,
    input  logic [EPP_DW-1:0] start_val,
    input  logic              wait_ok,
    input  logic              expired,
    input  logic [EPP_DW-1:0] pd_in,
    output logic              busy,
    output logic              active,
    output logic              abort,
    output logic              rd_done,
    output logic [EPP_DW-1:0] rd_val,
    output logic              nwrite,
    output logic              ndstb,
    output logic              nastb,
    output logic              oe,
    output logic [EPP_DW-1:0] dout
);
    eng_reg_t r_d, r_q;
    logic     strobe_on;

    always_comb begin
        r_d     = r_q;
        abort   = 1'b0;
        rd_done = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_END: begin
                if (start) begin
                    r_d.st  = ST_SETUP;
                    r_d.rd  = start_rd;
                    r_d.adr = start_adr;
                    r_d.val = start_val;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_SETUP: begin
                r_d.st = ST_STROBE;
            end
            ST_STROBE: begin
                if (wait_ok) begin
                    r_d.st  = ST_END;
                    rd_done = r_q.rd;
                end else if (expired) begin
                    r_d.st  = ST_END;
                    abort   = 1'b1;
                    rd_done = r_q.rd;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.rd  <= 1'b0;
            r_q.adr <= 1'b0;
            r_q.val <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_val    = wait_ok ? pd_in : '1;
    assign busy      = (r_q.st == ST_SETUP) || (r_q.st == ST_STROBE);
    assign active    = (r_q.st != ST_IDLE);
    assign strobe_on = (r_q.st == ST_STROBE);
    assign nwrite    = r_q.rd;
    assign oe        = !r_q.rd;
    assign dout      = r_q.val;
    assign ndstb     = !(strobe_on && !r_q.adr);
    assign nastb     = !(strobe_on && r_q.adr);
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
    import epp_pkg::*;
#(
    parameter int TMO_TICKS = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [EPP_DW-1:0] host_wdata,
    output logic [EPP_DW-1:0] host_rdata,
    output logic              host_busy,
    input  logic [EPP_DW-1:0] pd_in,
    output logic [EPP_DW-1:0] pd_out,
    output logic              pd_oe,
    output logic              pp_nwrite,
    output logic              pp_ndstb,
    output logic              pp_nastb,
    output logic              pp_ninit,
    input  logic              pp_nwait
);
    logic              wait_ok, wd_expired;
    logic              eng_busy, eng_active, eng_abort, eng_rd_done;
    logic [EPP_DW-1:0] eng_rd_val, eng_dout;
    logic              eng_nwrite, eng_ndstb, eng_nastb, eng_oe;
    logic              acc, start, is_epp, tmo_q;
    host_reg_t         r_d, r_q;

    epp_sync2 #(.W(1), .RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pp_nwait),
        .dout (wait_ok)
    );

    epp_wdog #(.LIMIT(TMO_TICKS)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (eng_busy),
        .tick   (tick),
        .expired(wd_expired)
    );

    epp_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_rd (!host_wr),
        .start_adr(host_addr == ADR_EPPADR),
        .start_val(host_wdata),
        .wait_ok  (wait_ok),
        .expired  (wd_expired),
        .pd_in    (pd_in),
        .busy     (eng_busy),
        .active   (eng_active),
        .abort    (eng_abort),
        .rd_done  (eng_rd_done),
        .rd_val   (eng_rd_val),
        .nwrite   (eng_nwrite),
        .ndstb    (eng_ndstb),
        .nastb    (eng_nastb),
        .oe       (eng_oe),
        .dout     (eng_dout)
    );

    assign acc    = (host_wr || host_rd) && !eng_busy;
    assign is_epp = (host_addr == ADR_EPPADR) || (host_addr == ADR_EPPDAT);
    assign start  = acc && is_epp;

    always_comb begin
        r_d = r_q;
        if (acc && host_wr) begin
            unique case (host_addr)
                ADR_DATA:   r_d.dlat = host_wdata;
                ADR_CTRL:   r_d.ctrl = host_wdata;
                ADR_STATUS: if (host_wdata[0]) r_d.tmo = 1'b0;
                default:    ;
            endcase
        end else if (acc && host_rd) begin
            unique case (host_addr)
                ADR_DATA:   r_d.rdata = pd_in;
                ADR_STATUS: r_d.rdata = {{(EPP_DW-1){1'b0}}, r_q.tmo};
                ADR_CTRL:   r_d.rdata = r_q.ctrl;
                ADR_EPPADR, ADR_EPPDAT: ;
                default:    r_d.rdata = '0;
            endcase
        end
        if (eng_abort)   r_d.tmo   = 1'b1;
        if (eng_rd_done) r_d.rdata = eng_rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= '0;
            r_q.dlat  <= '0;
            r_q.tmo   <= 1'b0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tmo_q      = r_q.tmo;
    assign host_rdata = r_q.rdata;
    assign host_busy  = eng_busy;
    assign pp_ninit   = r_q.ctrl[CB_INIT];
    assign pp_nwrite  = eng_active ? eng_nwrite : !r_q.ctrl[CB_WRLINE];
    assign pp_ndstb   = eng_active ? eng_ndstb  : !r_q.ctrl[CB_DSLINE];
    assign pp_nastb   = eng_active ? eng_nastb  : !r_q.ctrl[CB_ASLINE];
    assign pd_oe      = eng_active ? eng_oe     : !r_q.ctrl[CB_DIR];
    assign pd_out     = eng_active ? eng_dout   : r_q.dlat;
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_busy,
    input logic       host_wr,
    input logic [2:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       pp_ndstb,
    input logic       pp_nastb,
    input logic       pp_nwrite,
    input logic       pd_oe,
    input logic       wait_ok,
    input logic       wd_expired,
    input logic       tmo_q
);
    logic strobe_on;
    assign strobe_on = !pp_ndstb || !pp_nastb;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !(!pp_ndstb && !pp_nastb)); // R2

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && strobe_on && !pp_nwrite) |-> pd_oe); // R3

    AST_DIR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_on) && host_busy) |-> ($stable(pp_nwrite) && $stable(pd_oe))); // R4

    AST_DIR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe_on) && $past(host_busy)) |-> ($stable(pp_nwrite) && $stable(pd_oe))); // R3

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && strobe_on && !wait_ok && !wd_expired) |=> strobe_on); // R5

    AST_ABORT_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && strobe_on && !wait_ok && wd_expired) |=> (!host_busy && tmo_q)); // R6

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_q && !(host_wr && host_addr == 3'd1 && host_wdata[0])) |=> tmo_q); // R7

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_q && !host_busy && host_wr && host_addr == 3'd1 && host_wdata[0]) |=> !tmo_q); // R7
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_busy (host_busy),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .pp_ndstb  (pp_ndstb),
    .pp_nastb  (pp_nastb),
    .pp_nwrite (pp_nwrite),
    .pd_oe     (pd_oe),
    .wait_ok   (wait_ok),
    .wd_expired(wd_expired),
    .tmo_q     (tmo_q)
);

// File: tb/sim_epp_cycle_ctrl.sv
module sim_epp_cycle_ctrl;
    localparam int TMO = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_busy;
    logic [7:0] pd_in;
    logic [7:0] pd_out;
    logic       pd_oe, pp_nwrite, pp_ndstb, pp_nastb, pp_ninit;
    logic       pp_nwait = 1'b0;

    logic [7:0] periph_val = 8'h00;
    logic [7:0] bus_idle = 8'h3C;
    int         pdelay = 0;
    int         checks = 0;
    int         errors = 0;

    typedef struct {
        bit         rd;
        bit         adr;
        logic [7:0] val;
        bit         abort;
        int         minlow;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    wire son = !pp_ndstb || !pp_nastb;
    assign pd_in = (son && pp_nwrite) ? periph_val : bus_idle;

    epp_cycle_ctrl #(.TMO_TICKS(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_busy(host_busy),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .pp_nwrite(pp_nwrite), .pp_ndstb(pp_ndstb), .pp_nastb(pp_nastb),
        .pp_ninit(pp_ninit), .pp_nwait(pp_nwait)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // peripheral model: wait released pdelay clocks after a strobe falls
    initial begin
        int plow = 0;
        forever begin
            @(negedge clk);
            if (son) begin
                plow++;
                if (plow >= pdelay) pp_nwait = 1'b1;
            end else begin
                plow = 0;
                pp_nwait = 1'b0;
            end
        end
    end

    // monitor: pops expected cycles and compares them with the bus
    initial begin
        bit   in_cyc = 0;
        exp_t cur;
        int   low = 0;
        bit   sawa = 0, sawd = 0, side_bad = 0, order_bad = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                in_cyc = 0;
            end else begin
                if (!in_cyc && host_busy) begin
                    in_cyc = 1;
                    low = 0; sawa = 0; sawd = 0; side_bad = 0; order_bad = son;
                    if (sbq.size() == 0) begin
                        chk(0, "R8 unexpected cycle", 1, 0);
                        cur = '{rd: 0, adr: 0, val: 8'h00, abort: 0, minlow: 0};
                    end else begin
                        cur = sbq.pop_front();
                    end
                end
                if (in_cyc && host_busy) begin
                    if (son) low++;
                    if (!pp_nastb) sawa = 1;
                    if (!pp_ndstb) sawd = 1;
                    if (pp_nwrite != cur.rd || pd_oe != !cur.rd || (!cur.rd && pd_out != cur.val))
                        side_bad = 1;
                end else if (in_cyc) begin
                    in_cyc = 0;
                    chk(!order_bad, cur.rd ? "R4 strobe before setup" : "R3 strobe before setup", order_bad, 0);
                    chk(sawa == cur.adr && sawd == !cur.adr, "R2 strobe select",
                        {sawa, sawd}, {cur.adr, !cur.adr});
                    chk(!side_bad && !son && pp_nwrite == cur.rd && pd_oe == !cur.rd,
                        cur.rd ? "R4 direction levels" : "R3 direction and data levels",
                        {side_bad, son, pp_nwrite, pd_oe}, {2'b00, cur.rd, !cur.rd});
                    if (cur.abort)
                        chk(low == TMO, "R6 strobe length on abort", low, TMO);
                    else
                        chk(low > cur.minlow, "R5 wait states honoured", low, cur.minlow);
                    if (cur.rd)
                        chk(host_rdata == (cur.abort ? 8'hFF : cur.val),
                            cur.abort ? "R6 aborted read value" : "R4 read value",
                            host_rdata, cur.abort ? 8'hFF : cur.val);
                end
            end
        end
    end

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic epp(input bit rd, input bit adr, input logic [7:0] val, input int pd, input bit abort);
        exp_t e;
        logic [7:0] dummy;
        e.rd = rd; e.adr = adr; e.val = val; e.abort = abort; e.minlow = pd;
        sbq.push_back(e);
        pdelay = pd;
        periph_val = val;
        if (rd) hread(adr ? 3'd3 : 3'd4, dummy);
        else    hwrite(adr ? 3'd3 : 3'd4, val);
        while (host_busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(!host_busy, "R8 idle after reset", host_busy, 0);
        chk({pp_nwrite, pp_ndstb, pp_nastb, pp_ninit, pd_oe} == 5'b11101, "R1 reset fallback",
            {pp_nwrite, pp_ndstb, pp_nastb, pp_ninit, pd_oe}, 5'b11101);
        chk(pd_out == 8'h00, "R1 reset data latch", pd_out, 0);
        hread(3'd1, rv);
        chk(rv == 8'h00, "R7 status after reset", rv, 0);

        // standard-mode fallback
        hwrite(3'd2, 8'h2B);
        hwrite(3'd0, 8'hA5);
        chk({pp_nwrite, pp_ndstb, pp_nastb, pp_ninit, pd_oe} == 5'b00000, "R1 fallback set",
            {pp_nwrite, pp_ndstb, pp_nastb, pp_ninit, pd_oe}, 5'b00000);
        chk(pd_out == 8'hA5, "R1 data latch drives bus", pd_out, 8'hA5);
        hwrite(3'd2, 8'h04);
        chk({pp_nwrite, pp_ndstb, pp_nastb, pp_ninit, pd_oe} == 5'b11111, "R1 fallback clear",
            {pp_nwrite, pp_ndstb, pp_nastb, pp_ninit, pd_oe}, 5'b11111);
        hread(3'd2, rv);
        chk(rv == 8'h04, "R9 control readback", rv, 8'h04);
        hread(3'd0, rv);
        chk(rv == 8'h3C, "R9 data port reads bus", rv, 8'h3C);

        // write cycles
        epp(0, 0, 8'h5A, 0, 0);
        epp(0, 1, 8'hC3, 3, 0);
        epp(0, 0, 8'h81, 7, 0);
        @(negedge clk);
        chk(pd_out == 8'hA5 && pd_oe, "R1 fallback after cycle", {pd_oe, pd_out}, 9'h1A5);

        // read cycles
        hwrite(3'd2, 8'h24);
        epp(1, 0, 8'h96, 2, 0);
        epp(1, 1, 8'h69, 5, 0);
        hread(3'd1, rv);
        chk(rv == 8'h00, "R7 no timeout yet", rv, 0);

        // timeout on a write, sticky flag
        hwrite(3'd2, 8'h04);
        epp(0, 0, 8'hE7, 100000, 1);
        hread(3'd1, rv);
        chk(rv == 8'h01, "R6 timeout flag set", rv, 8'h01);
        epp(0, 1, 8'h12, 1, 0);
        hwrite(3'd1, 8'hFE);
        hread(3'd1, rv);
        chk(rv == 8'h01, "R7 flag sticky", rv, 8'h01);
        hwrite(3'd1, 8'h01);
        hread(3'd1, rv);
        chk(rv == 8'h00, "R7 flag cleared", rv, 8'h00);

        // timeout on a read
        hwrite(3'd2, 8'h24);
        epp(1, 1, 8'h44, 100000, 1);
        hread(3'd1, rv);
        chk(rv == 8'h01, "R6 read timeout flag", rv, 8'h01);
        hwrite(3'd1, 8'h01);

        // accesses while busy are ignored
        hwrite(3'd2, 8'h04);
        begin
            exp_t e;
            e.rd = 0; e.adr = 0; e.val = 8'h11; e.abort = 0; e.minlow = 10;
            sbq.push_back(e);
            pdelay = 10;
            hwrite(3'd4, 8'h11);
            chk(host_busy, "R8 busy after start", host_busy, 1);
            hwrite(3'd2, 8'h2B);
            hwrite(3'd4, 8'h77);
            hwrite(3'd0, 8'h00);
            while (host_busy) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(!host_busy && sbq.size() == 0, "R8 no second cycle", sbq.size(), 0);
        hread(3'd2, rv);
        chk(rv == 8'h04, "R8 control write ignored", rv, 8'h04);
        chk(pd_out == 8'hA5, "R8 data write ignored", pd_out, 8'hA5);

        // watchdog only counts on tick
        tick = 1'b0;
        epp(0, 0, 8'h3E, 40, 0);
        tick = 1'b1;
        hread(3'd1, rv);
        chk(rv == 8'h00, "R10 no timeout without tick", rv, 8'h00);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule